// File: doc/BRIEF.md
# Reloading Interval Timer with Frozen Readback

This block is a 14-bit interval timer reached through a bit-addressed register interface. A six-bit prescaler divides the system clock by 64, and each prescaler wrap moves a down-counter by one. Firmware sets a mode bit to enter clock mode. It then writes the start value one bit at a time, and every bit written reloads the counter and restarts the prescaler. When the counter has spent a full period at zero, it reloads from the start value and raises a timer interrupt request, provided the start value is nonzero.

A separate snapshot register copies the counter on each decrement, but only while the block is outside clock mode. On entry to clock mode the snapshot stops changing, so firmware can read all fourteen bits one address at a time and get a consistent value. The block leaves clock mode when firmware writes 0 to the mode bit. It also leaves clock mode whenever the select lines carry an address of 16 or above, and this happens even when chip select is inactive. Writes to the mask address while in interrupt mode clear the pending timer interrupt and set whether it is passed on.

Top module: `snap_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, the mode bit is 0, `tmr_irq` is 0, the start value, counter and snapshot are 0, and timer interrupts are disabled with the timer mask at 0.
- R2: The counter is 14 bits wide. When it is nonzero, it decrements by exactly one every 64 system clocks, and it holds its value in all other cycles.
- R3: A counter at zero stays at zero for one full 64-clock period. At the next decrement point it reloads from the start value.
- R4: In clock mode with chip select high, a write strobe at address k (1 to 14) sets start bit k-1 to `wr_val`. The same edge loads the counter with the updated start value and clears the prescaler, so the first decrement comes 64 clocks after the write.
- R5: After a start-bit write, timer interrupts are enabled if the new start value is nonzero. If it is zero, they are disabled and any pending timer interrupt is dropped.
- R6: Each reload from zero while timer interrupts are enabled sets a pending flag. `tmr_irq` is high when the flag is pending and the timer mask is 1.
- R7: In interrupt mode (mode bit 0), a write at address 3 clears the pending flag and stores `wr_val` as the timer mask. If a reload sets the flag in the same cycle, the set wins. The counter keeps running either way.
- R8: On each decrement the snapshot takes the new count only if the mode bit was 0 at that edge, and it never changes while the mode bit is 1. In clock mode with chip select high, address k (1 to 14) reads snapshot bit k-1 on `rd_val`.
- R9: A write at address 0 with chip select high sets the mode bit to `wr_val`, and address 0 reads the mode bit. Any cycle with `sel` at 16 or above clears the mode bit on the next edge, whatever chip select is.
- R10: With chip select low, write strobes change nothing and `rd_val` is 0.
- R11: In clock mode, a write at address 15 leaves the start value, the counter, the prescaler and the interrupt state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| chip_sel | input | 1 | Chip select, active high; gates reads and writes |
| sel | input | 5 | Bit address of the access |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_val | input | 1 | Data bit written |
| rd_val | output | 1 | Data bit read at `sel` |
| tmr_irq | output | 1 | Timer interrupt request (pending and mask) |

## Verification
The assertions check the cycle-level relations on every cycle. The counter holds between prescaler wraps, it reloads from the start value after a zero period, and a restart loads the freshly written value. The snapshot stays still in clock mode, a high address forces interrupt mode, and `tmr_irq` rises only when interrupts are enabled. Some behaviour shows up only over whole scenarios, and only the bench can show it. That includes the exact decrement count after several periods, the bit-to-address mapping of the start value, mask-write clearing with re-raising on the next reload, the zero start value dropping a pending request, and the address-15 and chip-select-low accesses having no effect on later snapshots.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
// Package ivt_pkg
// Shared defaults and fixed addresses for the interval timer.
// Assumes the start-value bits sit at addresses 1..CNT_W, below the exit range.
package ivt_pkg;
    localparam int DEF_CNT_W = 14;   // counter width
    localparam int DEF_PRE_W = 6;    // prescaler width (divide by 2**PRE_W)
    localparam int DEF_SEL_W = 5;    // bit-address width
    localparam int MODE_SEL  = 0;    // address of the mode bit
    localparam int MASK_SEL  = 3;    // address of the timer mask in interrupt mode
endpackage

// File: rtl/ivt_prescaler.sv
`timescale 1ns/1ps
// Module ivt_prescaler
// Free-running divider; tick is high for one clock every 2**PRE_W clocks.
// Assumes restart has priority and returns the divider to zero.
module ivt_prescaler #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    logic [PRE_W-1:0] div_q;

    // tick marks the last clock of each divider period
    assign tick = &div_q;

    // divider count, cleared by reset or restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_ctrl.sv
`timescale 1ns/1ps
// Module ivt_ctrl
// Decodes bit-addressed writes: mode bit, start value bits, timer mask;
// keeps the interrupt enable and pending flag.
// Assumes CNT_W < 2**(SEL_W-1) so start addresses never hit the exit range.
module ivt_ctrl #(
    parameter int CNT_W    = 14,
    parameter int SEL_W    = 5,
    parameter int MODE_SEL = 0,
    parameter int MASK_SEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_sel,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_stb,
    input  logic             wr_val,
    input  logic             zero_evt,
    output logic             mode_q,
    output logic             restart,
    output logic             en_q,
    output logic             mask_q,
    output logic             pend_q,
    output logic [CNT_W-1:0] start_q,
    output logic [CNT_W-1:0] start_nxt
);
    localparam int EXIT_SEL = 2 ** (SEL_W - 1);

    logic             wr_hit;
    logic             exit_sel;
    logic             mask_wr;
    logic             mode_wr;
    logic [CNT_W-1:0] bit_hit;

    assign wr_hit   = wr_stb & chip_sel;
    assign exit_sel = (sel >= SEL_W'(EXIT_SEL));
    assign mode_wr  = wr_hit && (sel == SEL_W'(MODE_SEL));
    assign mask_wr  = wr_hit && !mode_q && (sel == SEL_W'(MASK_SEL));

    // per-bit decode of start-value writes and the merged next start value
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        assign bit_hit[i]   = wr_hit && mode_q && (sel == SEL_W'(i + 1));
        assign start_nxt[i] = bit_hit[i] ? wr_val : start_q[i];
    end

    assign restart = |bit_hit;

    // mode bit: high addresses force interrupt mode regardless of chip select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (exit_sel) begin
            mode_q <= 1'b0;
        end else if (mode_wr) begin
            mode_q <= wr_val;
        end
    end

    // start value and interrupt enable follow each start-bit write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            en_q    <= 1'b0;
        end else if (restart) begin
            start_q <= start_nxt;
            en_q    <= |start_nxt;
        end
    end

    // timer mask written at the mask address in interrupt mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (mask_wr) begin
            mask_q <= wr_val;
        end
    end

    // pending flag: drop on zero start, set on enabled reload, clear on mask write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (restart && (start_nxt == '0)) begin
            pend_q <= 1'b0;
        end else if (zero_evt && en_q) begin
            pend_q <= 1'b1;
        end else if (mask_wr) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ivt_counter.sv
`timescale 1ns/1ps
// Module ivt_counter
// Down-counter with reload from the start value and a snapshot that copies
// the new count on each decrement while outside clock mode.
// Assumes restart and tick never both apply; restart wins.
module ivt_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             mode_q,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             zero_evt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] snap_q
);
    logic [CNT_W-1:0] cnt_step;

    assign zero_evt = tick && !restart && (cnt_q == '0);
    assign cnt_step = (cnt_q == '0) ? reload_val : cnt_q - 1'b1;

    // count register: restart load, otherwise step on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= cnt_step;
        end
    end

    // snapshot register: copies the stepped count only in interrupt mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (tick && !restart && !mode_q) begin
            snap_q <= cnt_step;
        end
    end
endmodule

// File: rtl/snap_interval_timer.sv
`timescale 1ns/1ps
// Module snap_interval_timer
// Top level: prescaled reloading down-counter with bit-addressed access,
// frozen snapshot readback and a maskable timer interrupt request.
// Assumes single-cycle write strobes and a synchronous active-low reset.
module snap_interval_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int PRE_W = DEF_PRE_W,
    parameter int SEL_W = DEF_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_sel,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_stb,
    input  logic             wr_val,
    output logic             rd_val,
    output logic             tmr_irq
);
    logic             tick;
    logic             restart;
    logic             zero_evt;
    logic             mode_q;
    logic             en_q;
    logic             mask_q;
    logic             pend_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] start_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] snap_sh;
    logic [SEL_W-1:0] rd_idx;

    ivt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    ivt_ctrl #(
        .CNT_W    (CNT_W),
        .SEL_W    (SEL_W),
        .MODE_SEL (MODE_SEL),
        .MASK_SEL (MASK_SEL)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_sel  (chip_sel),
        .sel       (sel),
        .wr_stb    (wr_stb),
        .wr_val    (wr_val),
        .zero_evt  (zero_evt),
        .mode_q    (mode_q),
        .restart   (restart),
        .en_q      (en_q),
        .mask_q    (mask_q),
        .pend_q    (pend_q),
        .start_q   (start_q),
        .start_nxt (start_nxt)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .restart    (restart),
        .mode_q     (mode_q),
        .load_val   (start_nxt),
        .reload_val (start_q),
        .zero_evt   (zero_evt),
        .cnt_q      (cnt_q),
        .snap_q     (snap_q)
    );

    assign tmr_irq = pend_q & mask_q;
    assign rd_idx  = sel - 1'b1;
    assign snap_sh = snap_q >> rd_idx;

    // read mux: mode bit at its address, snapshot bits in clock mode
    always_comb begin
        rd_val = 1'b0;
        if (chip_sel) begin
            if (sel == SEL_W'(MODE_SEL)) begin
                rd_val = mode_q;
            end else if (mode_q && (sel <= SEL_W'(CNT_W))) begin
                rd_val = snap_sh[0];
            end
        end
    end
endmodule

// File: rtl/ivt_checker.sv
`timescale 1ns/1ps
// Module ivt_checker
// Cycle-level properties of the interval timer, bound into the top module.
// Assumes the synchronous active-low reset is asserted from time zero.
module ivt_checker #(
    parameter int CNT_W = 14,
    parameter int SEL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_sel,
    input logic [SEL_W-1:0] sel,
    input logic             rd_val,
    input logic             tmr_irq,
    input logic             tick,
    input logic             restart,
    input logic             mode_q,
    input logic             en_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] start_q,
    input logic [CNT_W-1:0] start_nxt,
    input logic [CNT_W-1:0] snap_q
);
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q)); // R2

    AST_RELOAD_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && cnt_q == '0) |=> (cnt_q == $past(start_q))); // R3

    AST_RESTART_LOADS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == $past(start_nxt))); // R4

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_irq) |-> $past(en_q)); // R5

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |=> $stable(snap_q)); // R8

    AST_HIGH_SEL_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        sel[SEL_W-1] |=> !mode_q); // R9

    AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel |-> (rd_val == 1'b0)); // R10
endmodule

bind snap_interval_timer ivt_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_sel  (chip_sel),
    .sel       (sel),
    .rd_val    (rd_val),
    .tmr_irq   (tmr_irq),
    .tick      (tick),
    .restart   (restart),
    .mode_q    (mode_q),
    .en_q      (en_q),
    .cnt_q     (cnt_q),
    .start_q   (start_q),
    .start_nxt (start_nxt),
    .snap_q    (snap_q)
);

// File: tb/snap_interval_timer_tb_top.sv
`timescale 1ns/1ps
// Bench for snap_interval_timer: behavioural reference model compared on
// every clock, plus directed scenarios with expected values from the requirements.
module snap_interval_timer_tb_top;
    localparam int CNT_W  = 14;
    localparam int SEL_W  = 5;
    localparam int PERIOD = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chip_sel = 1'b0;
    logic [SEL_W-1:0] sel = '0;
    logic             wr_stb = 1'b0;
    logic             wr_val = 1'b0;
    logic             rd_val;
    logic             tmr_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    snap_interval_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_sel (chip_sel),
        .sel      (sel),
        .wr_stb   (wr_stb),
        .wr_val   (wr_val),
        .rd_val   (rd_val),
        .tmr_irq  (tmr_irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_mode, m_start, m_cnt, m_pre, m_en, m_mask, m_pend, m_snap;
    int m_a, m_omode, m_oen, m_ostart;
    bit m_wr;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_start = 0; m_cnt = 0; m_pre = 0;
            m_en = 0; m_mask = 0; m_pend = 0; m_snap = 0;
        end else begin
            m_wr = wr_stb && chip_sel;
            m_a = int'(sel);
            m_omode = m_mode; m_oen = m_en; m_ostart = m_start;
            if (m_wr && m_omode == 1 && m_a >= 1 && m_a <= CNT_W) begin
                if (wr_val) m_start = m_ostart | (1 << (m_a - 1));
                else        m_start = m_ostart & ~(1 << (m_a - 1));
                m_cnt = m_start; m_pre = 0;
                m_en = (m_start != 0) ? 1 : 0;
                if (m_en == 0) m_pend = 0;
            end else begin
                if (m_wr && m_omode == 0 && m_a == 3) begin
                    m_pend = 0; m_mask = int'(wr_val);
                end
                if (m_pre == PERIOD - 1) begin
                    m_pre = 0;
                    if (m_cnt == 0) begin
                        m_cnt = m_ostart;
                        if (m_oen == 1) m_pend = 1;
                    end else begin
                        m_cnt = m_cnt - 1;
                    end
                    if (m_omode == 0) m_snap = m_cnt;
                end else begin
                    m_pre = m_pre + 1;
                end
            end
            if (m_a >= 16) m_mode = 0;
            else if (m_wr && m_a == 0) m_mode = int'(wr_val);
        end
    end

    // per-cycle comparison, away from the active edge
    int exp_rd;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            exp_rd = 0;
            if (chip_sel) begin
                if (sel == 0) exp_rd = m_mode;
                else if (m_mode == 1 && sel <= CNT_W) exp_rd = (m_snap >> (int'(sel) - 1)) & 1;
            end
            chk("R8 rd_val vs model", int'(rd_val), exp_rd);
            chk("R6 tmr_irq vs model", int'(tmr_irq), m_pend & m_mask);
        end
    end

    task automatic wr(int a, bit v);
        @(posedge clk); #1;
        chip_sel = 1'b1; sel = SEL_W'(a); wr_val = v; wr_stb = 1'b1;
        @(posedge clk); #1;
        last = cyc;
        chip_sel = 1'b0; sel = '0; wr_val = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic wr_nocs(int a, bit v);
        @(posedge clk); #1;
        chip_sel = 1'b0; sel = SEL_W'(a); wr_val = v; wr_stb = 1'b1;
        @(posedge clk); #1;
        sel = '0; wr_val = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic rd_bit(int a, output int v);
        @(posedge clk); #1;
        chip_sel = 1'b1; sel = SEL_W'(a);
        @(negedge clk);
        v = int'(rd_val);
        @(posedge clk); #1;
        chip_sel = 1'b0; sel = '0;
    endtask

    task automatic rd_snap(output int v);
        int b;
        v = 0;
        for (int k = 1; k <= CNT_W; k++) begin
            rd_bit(k, b);
            v = v | (b << (k - 1));
        end
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(posedge clk);
        #1;
    endtask

    function automatic int exp_cnt(int st, int ld, int c);
        int n;
        if (st == 0) return 0;
        n = (c - ld) / PERIOD;
        return st - (n % (st + 1));
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            finish_run();
        end
    end

    int v, v2, ld, ld2, ld3, ld4, e;
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", int'(tmr_irq), 0);
        rd_bit(0, v);  chk("R1 mode after reset", v, 0);
        wr(0, 1'b1);
        rd_bit(0, v);  chk("R9 mode written to 1", v, 1);
        rd_snap(v);    chk("R1 snapshot after reset", v, 0);

        // load start value 5 through address 1 (bit0) and address 3 (bit2)
        wr(1, 1'b1); wr(3, 1'b1); ld = last;
        wr(0, 1'b0);
        wait_until(ld + 2 * PERIOD + 32);
        wr(0, 1'b1); e = last;
        rd_snap(v);  chk("R2 count after two periods", v, exp_cnt(5, ld, e));
        chk("R4 start bits 0 and 2 give 3 after two periods", v, 3);
        wait_until(ld + 4 * PERIOD + 10);
        rd_snap(v2); chk("R8 snapshot frozen in clock mode", v2, v);

        // zero state and reload
        wr(0, 1'b0); wait_until(ld + 5 * PERIOD + 20);
        wr(0, 1'b1); rd_snap(v); chk("R3 zero state held a period", v, 0);
        wr(0, 1'b0); wait_until(ld + 6 * PERIOD + 20);
        wr(0, 1'b1); rd_snap(v); chk("R3 reload from start", v, 5);
        chk("R6 masked pending stays low", int'(tmr_irq), 0);

        // mask handling
        wr(0, 1'b0); wr(3, 1'b1);
        @(negedge clk); chk("R7 mask write clears pending", int'(tmr_irq), 0);
        wait_until(ld + 12 * PERIOD - 8);  chk("R6 no irq before reload", int'(tmr_irq), 0);
        wait_until(ld + 12 * PERIOD + 4);  chk("R6 irq after reload", int'(tmr_irq), 1);
        wr(3, 1'b1);
        @(negedge clk); chk("R7 write 1 clears", int'(tmr_irq), 0);
        wait_until(ld + 18 * PERIOD + 4);  chk("R7 re-raised with mask 1", int'(tmr_irq), 1);
        wr(3, 1'b0);
        @(negedge clk); chk("R7 write 0 clears", int'(tmr_irq), 0);
        wait_until(ld + 24 * PERIOD + 4);  chk("R7 mask 0 suppresses", int'(tmr_irq), 0);
        wr(0, 1'b1); e = last;
        rd_snap(v);  chk("R7 counter keeps running", v, exp_cnt(5, ld, e));

        // address 15 in clock mode has no effect on the timer
        wr(15, 1'b1);
        wr(0, 1'b0); repeat (100) @(posedge clk);
        wr(0, 1'b1); e = last;
        rd_snap(v);  chk("R11 address 15 leaves timer alone", v, exp_cnt(5, ld, e));

        // chip select low: writes ignored, read returns 0
        wr_nocs(0, 1'b0);
        rd_bit(0, v); chk("R10 mode kept with chip select low", v, 1);
        wr_nocs(1, 1'b0);
        @(posedge clk); #1 sel = '0;
        @(negedge clk); chk("R10 rd_val low when unselected", int'(rd_val), 0);

        // high address leaves clock mode with chip select low
        @(posedge clk); #1 sel = SEL_W'(20);
        @(posedge clk); #1 sel = '0;
        rd_bit(0, v); chk("R9 high address exits clock mode", v, 0);
        repeat (50) @(posedge clk);
        wr(0, 1'b1); e = last;
        rd_snap(v);  chk("R10 unselected start write ignored", v, exp_cnt(5, ld, e));

        // restart by rewriting a bit with its current value
        wr(2, 1'b0); ld2 = last;
        wr(0, 1'b0); wait_until(ld2 + PERIOD + 30);
        wr(0, 1'b1); e = last;
        rd_snap(v);  chk("R4 restart from start value", v, exp_cnt(5, ld2, e));

        // top start bit at address 14, and address 3 as start bit in clock mode
        wr(14, 1'b1); wr(3, 1'b0); ld3 = last;
        wr(0, 1'b0); wait_until(ld3 + PERIOD + 20);
        wr(0, 1'b1); rd_snap(v);
        chk("R4 address 14 maps to bit 13", v, 32'h2000);

        // zero start value drops pending and disables
        wr(14, 1'b0); ld4 = last;
        wr(0, 1'b0); wr(3, 1'b1);
        wait_until(ld4 + 2 * PERIOD + 5);
        chk("R6 irq with start 1", int'(tmr_irq), 1);
        wr(0, 1'b1); wr(1, 1'b0);
        @(negedge clk); chk("R5 zero start drops pending", int'(tmr_irq), 0);
        wr(0, 1'b0); repeat (300) @(posedge clk);
        @(negedge clk); chk("R5 zero start stays disabled", int'(tmr_irq), 0);

        finish_run();
    end
endmodule